// File: doc/BRIEF.md
# Keyed Watchdog Timer with Programmable Reset Pulse

This block is a 32-bit watchdog on a simple word-wide register bus. A prescaler divides the system clock down to a 1 MHz tick. A down-counter decrements on that tick while the watchdog is running. Software keeps the system alive by writing a 16-bit key to the restart register, which reloads the counter. Any other value written there does nothing.

When the count runs out, the block can drive a system reset pulse. The pulse length, counted in ticks, is programmable. Its polarity and output drive are set through tagged writes to the pulse configuration register. An external inhibit input turns an expiry into a silent shutdown: the control register is cleared and no pulse is produced. Each access is a single-cycle word write or a read whose data is registered.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the registers read as follows: count 0x03EF1480, reload 0x03EF1480, control 0x00000010, pulse configuration 0x000000FF, spare 0. The reset output is idle, with `sys_rst_o` high and `sys_rst_oe` low.
- R2: The byte addresses are 0x00 count (read-only), 0x04 reload, 0x08 restart, 0x0C control, 0x18 pulse configuration and 0x1C spare storage. The spare register holds any value and has no effect.
  - The restart address reads 0.
  - Any other address reads 0 and ignores writes.
  - A write to 0x00 is ignored.
  - Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`, and holds until the next read.
- R3: A write to 0x08 whose low 16 bits equal 0x4755 loads the counter from the reload register. If the enable bit (control bit 0) is set, the countdown restarts. Any other value leaves the count unchanged.
- R4: A value written to the control register is stored with bits 11:8 forced to 0 and bit 4 forced to 1.
- R5: A control write that changes bit 0 from 0 to 1 loads the counter from the reload value and starts counting. A write that changes bit 0 from 1 to 0 freezes the count. A write that leaves bit 0 unchanged does not reload the counter.
- R6: While running, the count drops by one every CLK_HZ/TICK_HZ clocks, measured from the load. Expiry occurs on the tick that takes the count to 0. A reload value of 0 expires on the first tick.
- R7: A write to 0x18 always stores bits 19:0 as the pulse width. The top byte of the written value selects a configuration change:
  - 0xA5 sets bit 31 (active-high output).
  - 0x5A clears bit 31.
  - 0xA8 sets bit 30 (push-pull drive).
  - 0x8A clears bit 30.
  - Any other top byte leaves bits 31:30 unchanged.
  - Bits 29:20 read 0.
- R8: On expiry with the inhibit input low and control bit 1 set, the reset pulse is active for (width+1) ticks, which is (width+1)*CLK_HZ/TICK_HZ clocks. Counting stops, and the control register keeps its value.
- R9: On expiry with control bit 1 clear, no pulse is produced and counting stops.
- R10: On expiry with `inhibit_i` high, the control register becomes 0 and no pulse is produced.
- R11: `sys_rst_o` equals bit 31 while the pulse is active and its inverse otherwise. `sys_rst_oe` is 1 when bit 30 is set, and otherwise is 1 only while the pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| inhibit_i | input | 1 | Turns an expiry into a silent self-disable |
| sys_rst_o | output | 1 | Reset pulse level |
| sys_rst_oe | output | 1 | Reset output enable; low means undriven in open-drain mode |

## Verification
The assertions take three things for granted about the inputs:
- `inhibit_i` is synchronous to the clock.
- `bus_wr` and `bus_rd` are never high together.
- A write that stores the control register never lands on the cycle of an inhibited expiry; if it did, the expiry's clear would override it.

The bench changes inputs only on the falling edge and issues one access at a time. It schedules control writes either while the counter is stopped or long before the count can reach zero, so every expiry it provokes meets an idle bus.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 32;
  localparam int PW     = 20;

  localparam int OFS_COUNT  = 'h00;
  localparam int OFS_RELOAD = 'h04;
  localparam int OFS_KICK   = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_PULSE  = 'h18;
  localparam int OFS_SPARE  = 'h1C;

  localparam logic [15:0] KICK_KEY   = 16'h4755;
  localparam logic [7:0]  TAG_POL_HI = 8'hA5;
  localparam logic [7:0]  TAG_POL_LO = 8'h5A;
  localparam logic [7:0]  TAG_PP     = 8'hA8;
  localparam logic [7:0]  TAG_OD     = 8'h8A;

  localparam logic [DATA_W-1:0] COUNT_RST = 32'h03EF_1480;
  localparam logic [PW-1:0]     WIDTH_RST = 20'h000FF;
  localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0010;
  localparam logic [DATA_W-1:0] CTRL_CLR  = 32'h0000_0F00;

  localparam int C_EN     = 0;
  localparam int C_RSTSYS = 1;

  typedef struct packed {
    logic          pol_high;
    logic          push_pull;
    logic [PW-1:0] width;
  } pulse_cfg_t;
endpackage

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PC_W = $clog2(DIV);
      localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);
      logic [PC_W-1:0] pc_q, pc_d;

      assign tick_o = (pc_q == LAST);

      always_comb begin
        pc_d = pc_q + 1'b1;
        if (sync_i || tick_o) pc_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end
    end
  endgenerate
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;

  assign step     = run_i && tick_i && !load_i;
  assign expire_o = step && (cnt_q <= W'(1));
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                    cnt_d = load_val_i;
    else if (step && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] width_i,
  input  logic         tick_i,
  output logic         active_o
);
  logic         act_q, act_d;
  logic [W-1:0] left_q, left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    if (start_i) begin
      act_d  = 1'b1;
      left_d = width_i;
    end else if (act_q && tick_i) begin
      if (left_q == '0) act_d  = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              inhibit_i,
  output logic              sys_rst_o,
  output logic              sys_rst_oe
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] spare_q, spare_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  pulse_cfg_t        cfg_q, cfg_d;
  logic              run_q, run_d;

  logic              wr_reload, wr_kick, wr_ctrl, wr_pulse, wr_spare;
  logic [DATA_W-1:0] ctrl_wdata;
  logic              en_rise, en_fall, kick_ok, load_evt;
  logic              tick, expire, fire, pulse_active;
  logic [DATA_W-1:0] cnt_q;

  // Address decode
  assign wr_reload = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
  assign wr_kick   = bus_wr && (bus_addr == ADDR_W'(OFS_KICK));
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_pulse  = bus_wr && (bus_addr == ADDR_W'(OFS_PULSE));
  assign wr_spare  = bus_wr && (bus_addr == ADDR_W'(OFS_SPARE));

  assign ctrl_wdata = (bus_wdata & ~CTRL_CLR) | CTRL_RST;
  assign en_rise    = wr_ctrl &&  ctrl_wdata[C_EN] && !ctrl_q[C_EN];
  assign en_fall    = wr_ctrl && !ctrl_wdata[C_EN] &&  ctrl_q[C_EN];
  assign kick_ok    = wr_kick && (bus_wdata[15:0] == KICK_KEY);
  assign load_evt   = en_rise || kick_ok;
  assign fire       = expire && !inhibit_i && ctrl_q[C_RSTSYS];

  // Next-state logic
  always_comb begin
    reload_d = reload_q;
    spare_d  = spare_q;
    ctrl_d   = ctrl_q;
    cfg_d    = cfg_q;
    run_d    = run_q;
    rdata_d  = rdata_q;

    if (wr_reload) reload_d = bus_wdata;
    if (wr_spare)  spare_d  = bus_wdata;

    if (expire && inhibit_i) ctrl_d = '0;
    else if (wr_ctrl)        ctrl_d = ctrl_wdata;

    if (en_fall || expire)                        run_d = 1'b0;
    else if (en_rise || (kick_ok && ctrl_q[C_EN])) run_d = 1'b1;

    if (wr_pulse) begin
      cfg_d.width = bus_wdata[PW-1:0];
      case (bus_wdata[31:24])
        TAG_POL_HI: cfg_d.pol_high  = 1'b1;
        TAG_POL_LO: cfg_d.pol_high  = 1'b0;
        TAG_PP:     cfg_d.push_pull = 1'b1;
        TAG_OD:     cfg_d.push_pull = 1'b0;
        default:    ;
      endcase
    end

    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_COUNT):  rdata_d = cnt_q;
        ADDR_W'(OFS_RELOAD): rdata_d = reload_q;
        ADDR_W'(OFS_CTRL):   rdata_d = ctrl_q;
        ADDR_W'(OFS_PULSE):  rdata_d = {cfg_q.pol_high, cfg_q.push_pull,
                                        {(DATA_W-2-PW){1'b0}}, cfg_q.width};
        ADDR_W'(OFS_SPARE):  rdata_d = spare_q;
        default:             rdata_d = '0;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= COUNT_RST;
      spare_q  <= '0;
      ctrl_q   <= CTRL_RST;
      cfg_q    <= '{pol_high: 1'b0, push_pull: 1'b0, width: WIDTH_RST};
      run_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      reload_q <= reload_d;
      spare_q  <= spare_d;
      ctrl_q   <= ctrl_d;
      cfg_q    <= cfg_d;
      run_q    <= run_d;
      rdata_q  <= rdata_d;
    end
  end

  kwdt_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (load_evt),
    .tick_o (tick)
  );

  kwdt_count #(.W(DATA_W), .RST_VAL(COUNT_RST)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_evt),
    .load_val_i (reload_q),
    .run_i      (run_q),
    .tick_i     (tick),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  kwdt_pulse #(.W(PW)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (fire),
    .width_i  (cfg_q.width),
    .tick_i   (tick),
    .active_o (pulse_active)
  );

  assign bus_rdata  = rdata_q;
  assign sys_rst_o  = pulse_active ? cfg_q.pol_high : !cfg_q.pol_high;
  assign sys_rst_oe = cfg_q.push_pull || pulse_active;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inhibit_i,
  input logic        load,
  input logic        tick,
  input logic        run,
  input logic        expire,
  input logic        active,
  input logic [31:0] cnt,
  input logic [31:0] ctrl
);
  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt))); // R6

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(run && tick)) |=> $stable(cnt)); // R5

  AST_CTRL_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[11:8] == 4'h0); // R4

  AST_STOP_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run); // R8

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(expire) && !$past(inhibit_i) && $past(ctrl[1]))); // R8

  AST_INHIBIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && inhibit_i) |=> (ctrl == 32'h0 && !$rose(active))); // R10
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inhibit_i (inhibit_i),
  .load      (load_evt),
  .tick      (tick),
  .run       (run_q),
  .expire    (expire),
  .active    (pulse_active),
  .cnt       (cnt_q),
  .ctrl      (ctrl_q)
);

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
  localparam int DIV = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        inhibit_i = 1'b0;
  logic        sys_rst_o;
  logic        sys_rst_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kwdt_top u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inhibit_i(inhibit_i), .sys_rst_o(sys_rst_o), .sys_rst_oe(sys_rst_oe)
  );

  // Behavioural reference model
  logic [31:0] m_cnt, m_reload, m_ctrl, m_spare, m_rdata;
  logic [19:0] m_width, m_left;
  logic        m_pol, m_pp, m_run, m_act;
  int          m_pc;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] san;
    bit tk, ld, ex, rise, fall, key;
    if (!rst_n) begin
      m_cnt = 32'h03EF1480; m_reload = 32'h03EF1480; m_ctrl = 32'h10;
      m_spare = 0; m_rdata = 0; m_width = 20'hFF; m_left = 0;
      m_pol = 0; m_pp = 0; m_run = 0; m_act = 0; m_pc = 0;
    end else begin
      tk   = (m_pc == DIV - 1);
      san  = (bus_wdata & 32'hFFFF_F0FF) | 32'h10;
      rise = bus_wr && bus_addr == 8'h0C && san[0] && !m_ctrl[0];
      fall = bus_wr && bus_addr == 8'h0C && !san[0] && m_ctrl[0];
      key  = bus_wr && bus_addr == 8'h08 && bus_wdata[15:0] == 16'h4755;
      ld   = rise || key;
      ex   = m_run && tk && (m_cnt <= 1) && !ld;
      if (bus_rd) begin
        case (bus_addr)
          8'h00: m_rdata = m_cnt;
          8'h04: m_rdata = m_reload;
          8'h0C: m_rdata = m_ctrl;
          8'h18: m_rdata = {m_pol, m_pp, 10'h0, m_width};
          8'h1C: m_rdata = m_spare;
          default: m_rdata = 0;
        endcase
      end
      if (ex && !inhibit_i && m_ctrl[1]) begin
        m_act = 1; m_left = m_width;
      end else if (m_act && tk) begin
        if (m_left == 0) m_act = 0; else m_left = m_left - 1;
      end
      if (ld) m_cnt = m_reload;
      else if (m_run && tk && m_cnt != 0) m_cnt = m_cnt - 1;
      m_pc = (ld || tk) ? 0 : m_pc + 1;
      if (fall || ex) m_run = 0;
      else if (rise || (key && m_ctrl[0])) m_run = 1;
      if (ex && inhibit_i) m_ctrl = 0;
      else if (bus_wr && bus_addr == 8'h0C) m_ctrl = san;
      if (bus_wr && bus_addr == 8'h04) m_reload = bus_wdata;
      if (bus_wr && bus_addr == 8'h1C) m_spare = bus_wdata;
      if (bus_wr && bus_addr == 8'h18) begin
        m_width = bus_wdata[19:0];
        case (bus_wdata[31:24])
          8'hA5: m_pol = 1;
          8'h5A: m_pol = 0;
          8'hA8: m_pp = 1;
          8'h8A: m_pp = 0;
          default: ;
        endcase
      end
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2 model rdata actual=%h expected=%h", bus_rdata, m_rdata);
      end
      checks++;
      if (sys_rst_o !== (m_act ? m_pol : !m_pol) || sys_rst_oe !== (m_pp | m_act)) begin
        errors++;
        $display("FAIL R11 model out actual=%b/%b expected=%b/%b", sys_rst_o, sys_rst_oe,
                 m_act ? m_pol : !m_pol, m_pp | m_act);
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      summary();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_active(input int n, input logic lvl, input int exp, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_o === lvl) hits++;
    end
    checks++;
    if (hits != exp) begin
      errors++;
      $display("FAIL %s active cycles actual=%0d expected=%0d", tag, hits, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  logic [31:0] snap;

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    chk_bit(sys_rst_o, 1'b1, "R1 sys_rst_o idle");
    chk_bit(sys_rst_oe, 1'b0, "R1 sys_rst_oe idle");
    rd_chk(8'h00, 32'h03EF1480, "R1 count");
    rd_chk(8'h04, 32'h03EF1480, "R1 reload");
    rd_chk(8'h0C, 32'h00000010, "R1 ctrl");
    rd_chk(8'h18, 32'h000000FF, "R1 pulse cfg");
    rd_chk(8'h1C, 32'h00000000, "R1 spare");

    // R2 map, ignored writes
    wr(8'h00, 32'h1234_5678);
    rd_chk(8'h00, 32'h03EF1480, "R2 count read-only");
    rd_chk(8'h08, 32'h0, "R2 restart reads 0");
    wr(8'h1C, 32'hDEAD_BEEF);
    rd_chk(8'h1C, 32'hDEAD_BEEF, "R2 spare storage");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R2 unmapped");
    rd_chk(8'h0C, 32'h10, "R2 unmapped write no effect");

    // R4 sanitize
    wr(8'h0C, 32'hFFFF_FF0E);
    rd_chk(8'h0C, 32'hFFFF_F01E, "R4 ctrl sanitize");
    wr(8'h0C, 32'h0000_0002);
    rd_chk(8'h0C, 32'h0000_0012, "R4 ctrl bit4 forced");

    // R3 key checks while disabled
    wr(8'h04, 32'd7);
    wr(8'h08, 32'h1234_4756);
    rd_chk(8'h00, 32'h03EF1480, "R3 wrong key ignored");
    wr(8'h08, 32'hABCD_4755);
    rd_chk(8'h00, 32'd7, "R3 key reloads");

    // R5 enable start, freeze on disable
    wr(8'h04, 32'd1000);
    wr(8'h0C, 32'h3);
    idle(3 * DIV);
    wr(8'h0C, 32'h3);
    idle(DIV);
    wr(8'h0C, 32'h2);
    rd_chk(8'h00, 32'd996, "R5 count after 4 ticks, no reload on same-enable write");
    idle(3 * DIV);
    rd_chk(8'h00, 32'd996, "R5 count frozen");

    // R8 pulse width (active-low, open drain)
    wr(8'h18, 32'h0000_0003);
    wr(8'h04, 32'd4);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h3);
    chk_bit(sys_rst_oe, 1'b0, "R11 oe low idle open-drain");
    count_active(500, 1'b0, 4 * DIV, "R8 pulse length");
    rd_chk(8'h0C, 32'h13, "R8 ctrl kept");
    rd_chk(8'h00, 32'd0, "R8 counting stopped");

    // R7 tagged config writes
    wr(8'h18, 32'hA500_0002);
    rd_chk(8'h18, 32'h8000_0002, "R7 A5 sets pol");
    wr(8'h18, 32'hA800_0002);
    rd_chk(8'h18, 32'hC000_0002, "R7 A8 sets push-pull");
    wr(8'h18, 32'h12FF_FFFF);
    rd_chk(8'h18, 32'hC00F_FFFF, "R7 other tag keeps bits");
    wr(8'h18, 32'h5A00_0001);
    rd_chk(8'h18, 32'h4000_0001, "R7 5A clears pol");
    wr(8'h18, 32'h8A00_0001);
    rd_chk(8'h18, 32'h0000_0001, "R7 8A clears push-pull");

    // R11 active-high push-pull
    wr(8'h18, 32'hA500_0001);
    wr(8'h18, 32'hA800_0001);
    chk_bit(sys_rst_oe, 1'b1, "R11 oe high push-pull");
    chk_bit(sys_rst_o, 1'b0, "R11 idle level active-high");
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h3);
    count_active(300, 1'b1, 2 * DIV, "R11 active-high pulse");

    // R6 reload of zero: one tick then expiry
    wr(8'h04, 32'd0);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h3);
    count_active(200, 1'b1, 2 * DIV, "R6 zero reload expires");

    // R9 no reset-system bit
    wr(8'h04, 32'd2);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h1);
    count_active(250, 1'b1, 0, "R9 no pulse");
    rd_chk(8'h0C, 32'h11, "R9 ctrl kept");

    // R10 inhibit
    inhibit_i = 1;
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h3);
    count_active(250, 1'b1, 0, "R10 no pulse");
    rd_chk(8'h0C, 32'h0, "R10 ctrl cleared");
    inhibit_i = 0;

    // R3 key while enabled restarts
    wr(8'h04, 32'd3);
    wr(8'h0C, 32'h1);
    idle(2 * DIV);
    wr(8'h08, 32'h0000_4755);
    rd_chk(8'h00, 32'd3, "R3 key restarts when enabled");
    idle(4 * DIV);
    rd_chk(8'h00, 32'd0, "R6 expiry after reload ticks");

    idle(5);
    summary();
  end
endmodule